// File: doc/BRIEF.md
# Serial Option Word Loader with Power-Up Sequencer

This block sits between a host microcontroller and the analog section of a 13.56 MHz reader front end. The host programs it over two wires: a serial clock and a serial data line. A frame starts when the data line rises while the serial clock is high. The next 31 clock rising edges shift option bits in, starting with the least significant. The 32nd rising edge ends the frame. At that edge the whole option word is copied into the parallel register in a single step, and the block returns to normal mode. In normal mode the serial data line takes on a second job. It becomes the field modulation request: high asks for a reduced field or no field. The serial clock is expected to stay low in normal mode.

The block also runs the power-up sequence. A frame may be committed with the power bit set while the analog section is down. In that case the block waits until the receiver reports that it has settled, then drives a ready pulse of a fixed, parameterised length before it enters the running state. A short may be reported during start-up while short protection is enabled. In that case the block stops in a fault state: the ready line stays low and the fault line goes high. The enable pin powers down only the analog side. While the block is running, taking enable low and then high again resumes running with no new start-up. All serial and enable inputs pass through two-flop synchronisers into the reference clock domain before any edge detection.

Top module: `cfg_word_loader`

## Requirements
- R1: While reset is asserted (and after its release, until the first frame) the option word is 0, config mode is 0, and mod_req, dout and dout1 are all 0.
- R2: A rising edge on ser_data while ser_clk is high sets cfg_mode to 1 and restarts the bit count. This applies whatever the current mode is.
- R3: In config mode the first 31 ser_clk rising edges shift in ser_data. The bit taken at edge k becomes opt_word bit k-1, so the first bit lands in bit 0. opt_word stays unchanged until the 32nd edge.
- R4: The 32nd ser_clk rising edge copies all shifted bits to opt_word in one step and clears cfg_mode. The data present at that edge is discarded. opt_word bits 27 to 30 (the reserved option bits) and bit 31 are always 0.
- R5: A frame that is interrupted by a new frame start is dropped. Only the bits of the later frame reach opt_word.
- R6: ser_clk edges in normal mode leave opt_word and cfg_mode unchanged.
- R7: mod_req is the synchronised ser_data. It is gated so that it is 1 only in normal mode, with enable high and the sequencer running. It is 0 in config mode.
- R8: A commit with opt_word bit 0 (power) set, from any state other than running with enable high, starts start-up. After rx_settled, dout is high for exactly READY_CYC clock cycles, and the block then runs.
- R9: During start-up, short_det with opt_word bit 4 (short protection) set enters the fault state: dout stays 0 and dout1 is 1 until the next commit. With bit 4 clear, short_det is ignored. dout and dout1 are never high together.
- R10: Taking enable low while running forces mod_req to 0. Enable returning high restores mod_req within the sync latency, with no ready pulse.
- R11: A commit with power bit 0 powers down the sequencer. No ready pulse follows.
- R12: A commit with power bit 1 while running with enable high keeps running. No ready pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.56 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock from host (asynchronous) |
| ser_data | input | 1 | Serial data in config mode, modulation request in normal mode (asynchronous) |
| en | input | 1 | Analog enable (asynchronous) |
| short_det | input | 1 | Antenna driver short detected (clk domain) |
| rx_settled | input | 1 | Receiver operating point settled (clk domain) |
| opt_word | output | OPT_BITS+1 | Committed option word, option bit n at bit n-1 |
| cfg_mode | output | 1 | 1 while a frame is being received |
| mod_req | output | 1 | Field modulation request |
| dout | output | 1 | Ready pulse after start-up |
| dout1 | output | 1 | Start-up short fault level |

## Verification
Some properties are checked on every cycle:
- config mode blocks mod_req;
- opt_word holds steady through a frame;
- the reserved bits stay zero;
- ready and fault are never high together;
- mod_req is only ever high when enable was high two cycles earlier;
- a ready pulse never runs longer than READY_CYC.

Other behaviours can only be shown by the bench's scenarios:
- the bit ordering of a frame;
- the exact length of a ready pulse;
- dropping an interrupted frame;
- which commits start a pulse and which do not (already running, power off, fault, short with protection off);
- enable resuming running without a new start-up.

// File: rtl/cfgl_pkg.sv
// Package: shared state type and option word field positions for the
// serial option word loader.
package cfgl_pkg;

    // Power sequencer states.
    typedef enum logic [2:0] {
        PS_OFF   = 3'd0,
        PS_START = 3'd1,
        PS_READY = 3'd2,
        PS_RUN   = 3'd3,
        PS_FAULT = 3'd4
    } pwr_state_t;

    // Field positions inside the committed word (option bit n at bit n-1).
    localparam int PWR_BIT      = 0;  // power-up request
    localparam int SHORT_EN_BIT = 4;  // short protection enable

endpackage

// File: rtl/cfgl_sync.sv
// Module: cfgl_sync
// Multi-stage synchroniser for a bundle of independent asynchronous
// single-bit inputs. Assumes each bit is quasi-static relative to clk
// (no multi-bit coherency is provided or needed).
module cfgl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stg [STAGES];

    // First stage: capture the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_in;
    end

    // Remaining stages: one flop per stage, built from the parameter.
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
        end
    end

    assign d_out = stg[STAGES-1];

endmodule

// File: rtl/cfgl_frame_rx.sv
// Module: cfgl_frame_rx
// Detects the frame start (data rise while serial clock high). In config
// mode it shifts bits on serial clock rises, least significant option
// bit first, and commits the word in one step on the final edge.
// Assumes sclk_s/sdat_s are already synchronised to clk.
module cfgl_frame_rx #(
    parameter int OPT_BITS = 31,
    parameter int RSV_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output logic              cfg_mode,
    output logic [OPT_BITS:0] opt_word,
    output logic              commit
);

    localparam int CNT_W = $clog2(OPT_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OPT_BITS);

    // Mask clearing the reserved top option bits on commit.
    function automatic logic [OPT_BITS-1:0] keep_mask();
        logic [OPT_BITS-1:0] m;
        for (int i = 0; i < OPT_BITS; i++) m[i] = (i < OPT_BITS - RSV_BITS);
        return m;
    endfunction
    localparam logic [OPT_BITS-1:0] KEEP = keep_mask();

    logic                sclk_q, sdat_q;
    logic                sclk_rise, sdat_rise, frame_start;
    logic [CNT_W-1:0]    cnt;
    logic [OPT_BITS-1:0] sh;

    // Delayed copies of the synchronised lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sdat_q <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            sdat_q <= sdat_s;
        end
    end

    // Edge decode; a data rise under a high clock is a frame start.
    always_comb begin
        sclk_rise   = sclk_s & ~sclk_q;
        sdat_rise   = sdat_s & ~sdat_q;
        frame_start = sdat_rise & sclk_s;
    end

    // Frame state: mode flag, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mode <= 1'b0;
            cnt      <= '0;
            sh       <= '0;
        end else if (frame_start) begin
            cfg_mode <= 1'b1;
            cnt      <= '0;
            sh       <= '0;
        end else if (cfg_mode && sclk_rise) begin
            if (cnt == LAST) begin
                cfg_mode <= 1'b0;
                cnt      <= '0;
            end else begin
                sh  <= {sdat_s, sh[OPT_BITS-1:1]};
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Committed register: copied in one step on the final clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_word <= '0;
            commit   <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (!frame_start && cfg_mode && sclk_rise && cnt == LAST) begin
                opt_word <= {1'b0, sh & KEEP};
                commit   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfgl_power_seq.sv
// Module: cfgl_power_seq
// Start-up sequencer. On a commit that requests power while the analog
// side is down, it waits for the receiver to settle, checks for a short
// (when protection is on), then emits a READY_CYC-cycle ready pulse and
// runs. Assumes rx_settled and short_det are already in the clk domain.
module cfgl_power_seq
    import cfgl_pkg::*;
#(
    parameter int READY_CYC = 1356
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic pwr_req,
    input  logic short_en,
    input  logic en_s,
    input  logic rx_settled,
    input  logic short_det,
    output logic running,
    output logic dout,
    output logic dout1
);

    localparam int CW = $clog2(READY_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(READY_CYC - 1);

    pwr_state_t     state;
    logic [CW-1:0]  tmr;

    // State transitions; a commit takes priority over everything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_OFF;
            tmr   <= '0;
        end else if (commit) begin
            if (!pwr_req)                   state <= PS_OFF;
            else if (state == PS_RUN && en_s) state <= PS_RUN;
            else                            state <= PS_START;
        end else begin
            unique case (state)
                PS_START: begin
                    if (short_en && short_det) begin
                        state <= PS_FAULT;
                    end else if (en_s && rx_settled) begin
                        state <= PS_READY;
                        tmr   <= LOAD;
                    end
                end
                PS_READY: begin
                    if (!en_s)          state <= PS_START;
                    else if (tmr == '0) state <= PS_RUN;
                    else                tmr   <= tmr - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Output decode from the registered state.
    always_comb begin
        running = (state == PS_RUN);
        dout    = (state == PS_READY);
        dout1   = (state == PS_FAULT);
    end

endmodule

// File: rtl/cfg_word_loader.sv
// Module: cfg_word_loader (top)
// Two-wire option word loader whose data line doubles as the field
// modulation request in normal mode, plus the start-up/ready sequencer.
// Assumes clk is the reference clock and ser_clk is much slower than it.
module cfg_word_loader
    import cfgl_pkg::*;
#(
    parameter int OPT_BITS    = 31,
    parameter int RSV_BITS    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int READY_CYC   = 1356
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              en,
    input  logic              short_det,
    input  logic              rx_settled,
    output logic [OPT_BITS:0] opt_word,
    output logic              cfg_mode,
    output logic              mod_req,
    output logic              dout,
    output logic              dout1
);

    logic [2:0] raw_in, sync_out;
    logic       sclk_s, sdat_s, en_s;
    logic       commit, running;

    assign raw_in = {en, ser_data, ser_clk};
    assign {en_s, sdat_s, sclk_s} = sync_out;

    cfgl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (sync_out)
    );

    cfgl_frame_rx #(.OPT_BITS(OPT_BITS), .RSV_BITS(RSV_BITS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .sdat_s   (sdat_s),
        .cfg_mode (cfg_mode),
        .opt_word (opt_word),
        .commit   (commit)
    );

    cfgl_power_seq #(.READY_CYC(READY_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .pwr_req    (opt_word[PWR_BIT]),
        .short_en   (opt_word[SHORT_EN_BIT]),
        .en_s       (en_s),
        .rx_settled (rx_settled),
        .short_det  (short_det),
        .running    (running),
        .dout       (dout),
        .dout1      (dout1)
    );

    // Modulation request: data line only in normal, enabled, running mode.
    always_comb mod_req = sdat_s & ~cfg_mode & en_s & running;

endmodule

// File: rtl/cfgl_checker.sv
// Module: cfgl_checker
// Property checker bound to cfg_word_loader. Watches only the top's ports.
// Assumes the default two-stage synchroniser for the enable latency check.
module cfgl_checker #(
    parameter int OPT_BITS  = 31,
    parameter int RSV_BITS  = 4,
    parameter int READY_CYC = 1356
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [OPT_BITS:0] opt_word,
    input logic              cfg_mode,
    input logic              mod_req,
    input logic              dout,
    input logic              dout1
);

    localparam int LW = $clog2(READY_CYC + 2);
    logic [LW-1:0] run_len;

    // Length of the current ready pulse, saturating one past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                             run_len <= '0;
        else if (!dout)                         run_len <= '0;
        else if (run_len <= LW'(READY_CYC))     run_len <= run_len + 1'b1;
    end

    p_cfg_blocks_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |-> !mod_req);

    p_word_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && $past(cfg_mode)) |-> $stable(opt_word));

    p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        opt_word[OPT_BITS:OPT_BITS-RSV_BITS] == '0);

    p_ready_fault_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dout && dout1));

    p_mod_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mod_req |-> $past(en, 2));

    p_pulse_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= LW'(READY_CYC));

endmodule

bind cfg_word_loader cfgl_checker #(
    .OPT_BITS  (OPT_BITS),
    .RSV_BITS  (RSV_BITS),
    .READY_CYC (READY_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .opt_word (opt_word),
    .cfg_mode (cfg_mode),
    .mod_req  (mod_req),
    .dout     (dout),
    .dout1    (dout1)
);

// File: tb/cfg_word_loader_test.sv
// Bench for cfg_word_loader: a vector table of frames walked in one loop,
// then directed tests for reset, modulation, enable and framing corners.
module cfg_word_loader_test;

    localparam int READY = 50;
    localparam int H     = 4;   // clk cycles per serial phase

    typedef struct packed {
        logic [31:0] word;   // frame as sent (32 edges, last bit discarded)
        logic [31:0] exp;    // expected committed word
        logic        sh;     // short_det level during the frame
        logic        pulse;  // ready pulse expected
        logic        fault;  // fault level expected
    } vec_t;

    localparam vec_t TV [6] = '{
        '{32'h0200_4033, 32'h0200_4033, 1'b0, 1'b1, 1'b0}, // R8 start-up from off
        '{32'h0200_4033, 32'h0200_4033, 1'b0, 1'b0, 1'b0}, // R12 already running
        '{32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0}, // R11 power off
        '{32'h7800_0011, 32'h0000_0011, 1'b1, 1'b0, 1'b1}, // R9 fault, R4 reserved mask
        '{32'h0000_0001, 32'h0000_0001, 1'b1, 1'b1, 1'b0}, // R9 short ignored unprotected
        '{32'h8000_0021, 32'h0000_0021, 1'b0, 1'b0, 1'b0}  // R4 32nd bit dropped, R12
    };

    logic        clk = 1'b0;
    logic        rst_n, ser_clk, ser_data, en, short_det, rx_settled;
    logic [31:0] opt_word;
    logic        cfg_mode, mod_req, dout, dout1;

    int errs   = 0;
    int checks = 0;
    int pulse_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cfg_word_loader #(.READY_CYC(READY)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .en         (en),
        .short_det  (short_det),
        .rx_settled (rx_settled),
        .opt_word   (opt_word),
        .cfg_mode   (cfg_mode),
        .mod_req    (mod_req),
        .dout       (dout),
        .dout1      (dout1)
    );

    // Count ready-pulse cycles at the port.
    always @(negedge clk) if (dout === 1'b1) pulse_cnt = pulse_cnt + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Frame start, then nedges clock rises carrying w[0], w[1], ...
    task automatic send_frame(input logic [31:0] w, input int nedges);
        ser_clk = 1'b0; ser_data = 1'b0; wait_n(H);
        ser_clk = 1'b1; wait_n(H);
        ser_data = 1'b1; wait_n(H);
        ser_clk = 1'b0; wait_n(H);
        for (int i = 0; i < nedges; i++) begin
            ser_data = w[i]; wait_n(H);
            ser_clk = 1'b1;  wait_n(H);
            ser_clk = 1'b0;  wait_n(H);
        end
        ser_data = 1'b0; wait_n(H);
    endtask

    initial begin
        rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0;
        en = 1'b1; short_det = 1'b0; rx_settled = 1'b1;
        wait_n(5);
        check(opt_word == 32'h0 && !cfg_mode && !mod_req && !dout && !dout1,
              "R1", "reset outputs", {opt_word[27:0], cfg_mode, mod_req, dout, dout1}, 32'h0);
        rst_n = 1'b1;
        wait_n(5);
        check(opt_word == 32'h0 && !cfg_mode, "R1", "after release",
              opt_word, 32'h0);

        // Table of frames.
        for (int i = 0; i < 6; i++) begin
            short_det = TV[i].sh;
            wait_n(5);
            pulse_cnt = 0;
            send_frame(TV[i].word, 32);
            wait_n(READY + 60);
            check(opt_word == TV[i].exp, "R4", $sformatf("vec %0d word", i),
                  opt_word, TV[i].exp);
            check(!cfg_mode, "R4", $sformatf("vec %0d mode exit", i),
                  32'(cfg_mode), 32'h0);
            check(pulse_cnt == (TV[i].pulse ? READY : 0), "R8",
                  $sformatf("vec %0d ready cycles (R11/R12)", i),
                  32'(pulse_cnt), TV[i].pulse ? READY : 0);
            check(dout1 == TV[i].fault, "R9", $sformatf("vec %0d fault", i),
                  32'(dout1), 32'(TV[i].fault));
        end
        short_det = 1'b0;

        // R7: data line drives modulation in normal running mode.
        ser_data = 1'b1; wait_n(H);
        check(mod_req == 1'b1, "R7", "mod_req high", 32'(mod_req), 32'h1);
        ser_data = 1'b0; wait_n(H);
        check(mod_req == 1'b0, "R7", "mod_req low", 32'(mod_req), 32'h0);

        // R10: enable low suppresses, high restores without a new pulse.
        pulse_cnt = 0;
        en = 1'b0; ser_data = 1'b1; wait_n(6);
        check(mod_req == 1'b0, "R10", "mod_req with en low", 32'(mod_req), 32'h0);
        en = 1'b1; wait_n(H);
        check(mod_req == 1'b1, "R10", "mod_req restored", 32'(mod_req), 32'h1);
        wait_n(READY + 20);
        check(pulse_cnt == 0, "R10", "no ready pulse", 32'(pulse_cnt), 32'h0);
        ser_data = 1'b0; wait_n(H);

        // R6: clock activity in normal mode is ignored.
        for (int k = 0; k < 5; k++) begin
            ser_data = k[0]; wait_n(H);
            ser_clk = 1'b1;  wait_n(H);
            ser_clk = 1'b0;  wait_n(H);
        end
        ser_data = 1'b0; wait_n(H);
        check(opt_word == 32'h21 && !cfg_mode, "R6", "normal-mode clocks",
              opt_word, 32'h21);

        // R2/R3: partial frame enters config, word frozen, mod_req blocked.
        send_frame(32'hFFFF_FFFF, 10);
        check(cfg_mode == 1'b1, "R2", "frame start sets mode", 32'(cfg_mode), 32'h1);
        check(opt_word == 32'h21, "R3", "word frozen mid-frame", opt_word, 32'h21);
        ser_data = 1'b1; wait_n(H);
        check(mod_req == 1'b0, "R7", "mod_req in config", 32'(mod_req), 32'h0);
        ser_data = 1'b0; wait_n(H);

        // R5: interrupted frame discarded, later frame alone is taken.
        send_frame(32'h0000_0005, 32);
        wait_n(10);
        check(opt_word == 32'h5, "R5", "later frame only", opt_word, 32'h5);

        // R3/R4: 31 edges keep config; the 32nd commits.
        send_frame(32'h0000_0007, 31);
        check(cfg_mode == 1'b1 && opt_word == 32'h5, "R3", "after 31 edges",
              opt_word, 32'h5);
        ser_clk = 1'b1; wait_n(H);
        ser_clk = 1'b0; wait_n(H);
        check(cfg_mode == 1'b0, "R4", "32nd edge exits", 32'(cfg_mode), 32'h0);
        check(opt_word == 32'h7, "R4", "32nd edge commits", opt_word, 32'h7);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule